// File: doc/BRIEF.md
# Branching Memory-Hard Mix Sequencer

This block runs a two-phase mixing loop over a private scratchpad of `N` state-sized words. A start pulse loads a seed as the running state `X`. The first phase fills the scratchpad with successive states. The second phase runs `N` data-dependent iterations. In each one, an index taken from the state is compared against three thresholds set by a branching factor `B`. The outcome picks one of four read/mix/write-back actions. When the loop ends, a one-cycle done pulse marks the final state on the result output.

The mixing round `H` is a fixed one-cycle placeholder, so the final state can be reproduced exactly in software. A build parameter selects a branch-free datapath. That variant computes `H` once per iteration from masked operands and writes the state and both scratchpad slots every iteration. The masks make sure only the selected target changes. Both variants produce the same result.

Top module: `mix_sequencer`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: A `start` pulse in the idle state loads `seed` into `X`. A `start` seen while a run is in progress is ignored and does not change that run's result.
- R3: The fill phase runs `N` iterations, one per cycle. Iteration `i` stores `X` into entry `i` and then sets `X` to `H(X)`.
- R4: `X` is two W-bit halves `{a, b}` (a in the upper half). `H` is defined as follows: `t = a + b + K` (mod 2^W), `r = t` rotated left by 5, and `H(X) = {r, b ^ r}`. The defaults are W=16 and K=16'h9E37.
- R5: Each second-phase iteration takes two cycles. Its index `j` is the low log2(N) bits of `b` and stays fixed for the whole iteration.
- R6: If `j > N/B`, the iteration sets `X` to `H(X ^ V[j])`.
- R7: Otherwise, if `j > N/(2B)`, the iteration writes `H(X ^ V[j])` into entry `i`, and `X` does not change.
- R8: Otherwise, if `j > N/(4B)`, the iteration writes `H(X ^ V[i])` into entry `j`, and `X` does not change.
- R9: Otherwise, the iteration sets `X` to `H(X ^ V[i])`.
- R10: A scratchpad write made by one iteration is seen by every later read, including the read in the next iteration.
- R11: `done` is high for exactly one cycle, `3N` clock edges after the edge that accepted `start`. `result` then holds the final `X` until the next start.
- R12: The branch-free build (`BRANCHLESS=1`) gives a result identical to the branching build for every seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| seed | input | 2*W | Initial state loaded on start |
| done | output | 1 | One-cycle pulse at the end of a run |
| result | output | 2*W | Running state; holds the final value after done |

## Verification
Some rules hold in every cycle, and the embedded assertions check those. The fill counter advances by one per fill cycle. The state stays put across the read cycle and across the two scratchpad-write cases. Done never lasts more than one cycle.

Other behaviour is only visible through the bench's scenarios. These include the arithmetic of `H`, the branch selection, whether a write is seen by later reads, and the immunity of a run to a second start. The bench compares the exact final state and the done timing against a behavioural model, for both builds and for seeds that reach all four branches.

// File: rtl/mix_sequencer.sv
module mix_sequencer #(
  parameter int W = 16,
  parameter int N = 16,
  parameter int B = 2,
  parameter int ROT = 5,
  parameter bit BRANCHLESS = 0,
  parameter logic [W-1:0] K = 16'h9E37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2*W-1:0] seed,
  output logic         done,
  output logic [2*W-1:0] result
);
  localparam int SW = 2 * W;
  localparam int LGN = $clog2(N);
  localparam logic [LGN:0] TA = (LGN+1)'(N / B);
  localparam logic [LGN:0] TB = (LGN+1)'(N / (2 * B));
  localparam logic [LGN:0] TC = (LGN+1)'(N / (4 * B));

  typedef enum logic [2:0] {IDLE, FILL, READ, MIX, FIN} st_t;

  function automatic logic [SW-1:0] h(input logic [SW-1:0] v);
    logic [W-1:0] t, r;
    t = v[SW-1:W] + v[W-1:0] + K;
    r = (t << ROT) | (t >> (W - ROT));
    return {r, v[W-1:0] ^ r};
  endfunction

  st_t st;
  logic [SW-1:0] x, vi, vj, x_n, wdi, wdj;
  logic [SW-1:0] mem [N];
  logic [LGN-1:0] i, j;
  logic ca, cb, cc, cd, wr_i, wr_j, i_last;

  assign j = x[LGN-1:0];
  assign i_last = (i == LGN'(N - 1));
  assign ca = {1'b0, j} > TA;
  assign cb = !ca && ({1'b0, j} > TB);
  assign cc = !ca && !cb && ({1'b0, j} > TC);
  assign cd = !ca && !cb && !cc;
  assign done = (st == FIN);
  assign result = x;

  generate
    if (BRANCHLESS) begin : g_masked
      logic [SW-1:0] m_sel, m_x, m_i, m_j, hv;
      always_comb begin
        m_sel = {SW{ca | cb}};
        m_x   = {SW{ca | cd}};
        m_i   = {SW{cb}};
        m_j   = {SW{cc}};
        hv    = h(x ^ ((vj & m_sel) | (vi & ~m_sel)));
        x_n   = (hv & m_x) | (x & ~m_x);
        wdi   = (hv & m_i) | (vi & ~m_i);
        wdj   = (hv & m_j) | (vj & ~m_j);
        wr_i  = 1'b1;
        wr_j  = (j != i) || cc;
      end
    end else begin : g_branch
      logic [SW-1:0] hv;
      always_comb begin
        hv   = h(x ^ ((ca || cb) ? vj : vi));
        x_n  = (ca || cd) ? hv : x;
        wdi  = hv;
        wdj  = hv;
        wr_i = cb;
        wr_j = cc;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      x  <= '0;
      i  <= '0;
      vi <= '0;
      vj <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          x  <= seed;
          i  <= '0;
          st <= FILL;
        end
        FILL: begin
          x <= h(x);
          i <= i + 1'b1;
          if (i_last) st <= READ;
        end
        READ: begin
          vi <= mem[i];
          vj <= mem[j];
          st <= MIX;
        end
        MIX: begin
          x <= x_n;
          i <= i + 1'b1;
          st <= i_last ? FIN : READ;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == FILL) mem[i] <= x;
    if (st == MIX) begin
      if (wr_i) mem[i] <= wdi;
      if (wr_j) mem[j] <= wdj;
    end
  end

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FILL) |=> (i == LGN'($past(i) + 1'b1)));
  assert_index_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == READ) |=> $stable(x));
  assert_vi_write_keeps_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MIX && cb) |=> $stable(x));
  assert_vj_write_keeps_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MIX && cc) |=> $stable(x));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(result));
endmodule

// File: tb/mix_sequencer_tb.sv
module mix_sequencer_tb;
  localparam int N = 16;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] seed = '0;
  logic done, done_bf;
  logic [31:0] result, result_bf;
  int checks = 0, errors = 0;
  int hits [4] = '{0, 0, 0, 0};
  bit finished = 0;

  always #10 clk = ~clk;

  mix_sequencer u_dut (.clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
                       .done(done), .result(result));
  mix_sequencer #(.BRANCHLESS(1)) u_dut_bf (.clk(clk), .rst_n(rst_n), .start(start),
                       .seed(seed), .done(done_bf), .result(result_bf));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hm(input logic [31:0] v);
    logic [15:0] t, r;
    t = v[31:16] + v[15:0] + 16'h9E37;
    r = {t[10:0], t[15:11]};
    return {r, v[15:0] ^ r};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] s);
    logic [31:0] v [N];
    logic [31:0] x = s;
    int j;
    for (int k = 0; k < N; k++) begin
      v[k] = x;
      x = hm(x);
    end
    for (int k = 0; k < N; k++) begin
      j = int'(x[3:0]);
      if (j > 8) begin x = hm(x ^ v[j]); hits[0]++; end
      else if (j > 4) begin v[k] = hm(x ^ v[j]); hits[1]++; end
      else if (j > 2) begin v[j] = hm(x ^ v[k]); hits[2]++; end
      else begin x = hm(x ^ v[k]); hits[3]++; end
    end
    return x;
  endfunction

  task automatic run(input logic [31:0] s, input bit poke);
    logic [31:0] exp;
    exp = model(s);
    @(negedge clk);
    start = 1; seed = s;
    @(negedge clk);
    for (int k = 0; k <= 3 * N + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && (k == 10 || k == 3 * N - 1)) begin start = 1; seed = ~s; end
      else start = 0;
      check(done == (k == 3 * N), "R11 done timing", 32'(done), 32'(k == 3 * N));
      check(done_bf == (k == 3 * N), "R12 done timing branch-free", 32'(done_bf), 32'(k == 3 * N));
      if (k == 3 * N) begin
        check(result == exp, "R2 R3 R4 R5 R6 R7 R8 R9 R10 final state", result, exp);
        check(result_bf == exp, "R12 branch-free final state", result_bf, exp);
      end
    end
    start = 0;
    repeat (4) @(negedge clk);
    check(result == exp, "R11 result held", result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0, "R1 done after reset", 32'(done), 0);
    check(result == 0, "R1 result after reset", result, 0);
    rst_n = 1;
    run(32'h0000_0000, 0);
    run(32'hFFFF_FFFF, 0);
    run(32'h1234_5678, 1);
    run(32'hDEAD_BEEF, 0);
    run(32'h0000_0001, 0);
    run(32'hA5A5_0F0F, 1);
    run(32'h8000_7FFF, 0);
    for (int c = 0; c < 4; c++)
      check(hits[c] > 0, "R6 R7 R8 R9 branch reached", 32'(hits[c]), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule